// File: doc/BRIEF.md
# SPI Command Receiver with Parity Gate

This block is a receive-only SPI slave that turns serial command frames from an external master into registered command fields for game logic. The serial clock, data and chip-select lines arrive asynchronously. They are passed through flop synchronizers and sampled in one fast system clock domain. The block collects one frame for each chip-select assertion. When chip-select is released, it judges the frame by its bit count and its parity. Only a frame that passes both checks reaches the outputs. An accepted frame raises a one-clock valid pulse, which the game logic uses to fire move and rotate actions.

A frame is 16 bits and is sent most significant bit first. Bits [15:12] hold the opcode, bits [11:9] a 3-bit random value, bits [8:1] the keyboard state, and bit 0 makes the parity of the whole frame even. A rejected frame does not change the command registers. Instead it sets a sticky status flag: one flag for a wrong bit count and one for bad parity. An accepted frame with the clear opcode 4'hF resets both flags.

A three-state controller sequences the work:
- IDLE goes to RECV when the synchronized chip-select falls.
- RECV goes to EVAL when chip-select rises.
- EVAL always lasts one clock. From EVAL the controller returns to IDLE, or goes straight to RECV if chip-select has already fallen again.

Top module: `spi_cmd_rx`

## Requirements
- R1: After reset, the valid pulse is low, the opcode, random and key outputs are zero, and both error flags are clear.
- R2: A frame of exactly 16 bits with even parity over all 16 bits is accepted. Its bits [15:12] appear on the opcode output, bits [11:9] on the random output and bits [8:1] on the key output, with the first bit sent as bit 15.
- R3: For an accepted frame, the valid output is high for exactly one clock. If k is the first rising clock edge that samples chip-select high, valid is high from edge k+3 to edge k+4, and the data outputs change at edge k+3.
- R4: A 16-bit frame with odd parity sets the parity-error flag at edge k+3. It gives no valid pulse and leaves the opcode, random and key outputs unchanged.
- R5: A frame with fewer or more than 16 sampled bits sets the framing-error flag. It gives no valid pulse and leaves the data outputs unchanged.
- R6: Both error flags stay set through later accepted frames whose opcode is not 4'hF.
- R7: An accepted frame with opcode 4'hF clears both error flags and pulses valid. It leaves the opcode, random and key outputs unchanged. A 4'hF frame with bad parity clears nothing.
- R8: Data is sampled only on serial-clock rising edges while chip-select is low. Serial-clock activity while chip-select is high produces no valid pulse and changes no output. Serial-clock half-periods as short as one system clock are captured.
- R9: A new frame may begin one clock after chip-select is released. Both frames are then evaluated and accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck_i | input | 1 | Serial clock from the master (asynchronous) |
| spi_mosi_i | input | 1 | Serial data from the master (asynchronous) |
| spi_cs_n_i | input | 1 | Active-low chip-select (asynchronous) |
| cmd_valid_o | output | 1 | One-clock pulse for each accepted frame |
| cmd_op_o | output | 4 | Opcode of the last accepted non-clear frame |
| cmd_rand_o | output | 3 | Random field of the last accepted non-clear frame |
| cmd_keys_o | output | 8 | Keyboard bits of the last accepted non-clear frame |
| parity_err_o | output | 1 | Sticky parity-error flag |
| framing_err_o | output | 1 | Sticky bit-count error flag |

## Verification
The bench builds the block with its default parameters: a 16-bit frame, 4/3/8-bit fields, two synchronizer stages and 4'hF as the clear opcode. With these values a 12-bit frame and a 17-bit frame are cheap to send, so the bench reaches both the under-count path and the saturating over-count path. With two synchronizer stages, the three-edge latency from raw chip-select to the valid pulse is short enough to check exactly. The stimulus also covers one-clock serial-clock half-periods and a one-clock gap between frames, which stresses the edge detectors and the EVAL-to-RECV transition.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    // Controller states
    typedef enum logic [1:0] {
        S_IDLE,
        S_RECV,
        S_EVAL
    } rx_state_e;

    // Default frame geometry
    localparam int unsigned DEF_FRAME_W = 16;
    localparam int unsigned DEF_OP_W    = 4;
    localparam int unsigned DEF_RND_W   = 3;
    localparam int unsigned DEF_KEY_W   = 8;
    localparam int unsigned DEF_SYNC    = 2;

endpackage

// File: rtl/spi_cmd_sync.sv
module spi_cmd_sync #(
    parameter int unsigned W       = 3,
    parameter int unsigned STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [W-1:0] stg [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stg[g] <= RST_VAL;
                    else        stg[g] <= stg[g-1];
                end
            end
        end
    endgenerate

    assign dout = stg[STAGES-1];

endmodule

// File: rtl/spi_cmd_shifter.sv
module spi_cmd_shifter #(
    parameter int unsigned FRAME_W = 16,
    localparam int unsigned CW     = $clog2(FRAME_W + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr_i,
    input  logic               en_i,
    input  logic               din_i,
    output logic [FRAME_W-1:0] data_o,
    output logic [CW-1:0]      cnt_o
);

    localparam logic [CW-1:0] CNT_SAT = CW'(FRAME_W + 1);

    logic [CW-1:0] cnt_base;
    logic [CW-1:0] cnt_next;

    always_comb begin
        cnt_base = clr_i ? '0 : cnt_o;
        cnt_next = cnt_base;
        if (en_i && (cnt_base != CNT_SAT)) cnt_next = cnt_base + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            cnt_o  <= '0;
        end else begin
            cnt_o <= cnt_next;
            if (en_i) data_o <= {data_o[FRAME_W-2:0], din_i};
        end
    end

    // R5: the bit counter saturates one past a full frame
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_o <= CNT_SAT);

    // R8: the frame register moves only on a qualified sample
    p_shift_only_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(en_i) |-> $stable(data_o));

endmodule

// File: rtl/spi_cmd_rx.sv
module spi_cmd_rx
    import spi_cmd_pkg::*;
#(
    parameter int unsigned FRAME_W     = DEF_FRAME_W,
    parameter int unsigned OP_W        = DEF_OP_W,
    parameter int unsigned RND_W       = DEF_RND_W,
    parameter int unsigned KEY_W       = DEF_KEY_W,
    parameter int unsigned SYNC_STAGES = DEF_SYNC,
    parameter logic [OP_W-1:0] CLR_OP  = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spi_sck_i,
    input  logic             spi_mosi_i,
    input  logic             spi_cs_n_i,
    output logic             cmd_valid_o,
    output logic [OP_W-1:0]  cmd_op_o,
    output logic [RND_W-1:0] cmd_rand_o,
    output logic [KEY_W-1:0] cmd_keys_o,
    output logic             parity_err_o,
    output logic             framing_err_o
);

    localparam int unsigned OP_LSB  = FRAME_W - OP_W;
    localparam int unsigned RND_LSB = OP_LSB - RND_W;
    localparam int unsigned KEY_LSB = RND_LSB - KEY_W;
    localparam int unsigned CW      = $clog2(FRAME_W + 2);

    // Synchronized lines: {cs_n, mosi, sck}
    logic [2:0] line_s;
    logic       sck_s, mosi_s, cs_s;
    logic       sck_p, cs_p;
    logic       sck_rise, cs_fall, cs_rise, sample_en;

    spi_cmd_sync #(
        .W       (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({spi_cs_n_i, spi_mosi_i, spi_sck_i}),
        .dout  (line_s)
    );

    assign sck_s  = line_s[0];
    assign mosi_s = line_s[1];
    assign cs_s   = line_s[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_p <= 1'b0;
            cs_p  <= 1'b1;
        end else begin
            sck_p <= sck_s;
            cs_p  <= cs_s;
        end
    end

    assign sck_rise  = sck_s & ~sck_p;
    assign cs_fall   = ~cs_s & cs_p;
    assign cs_rise   = cs_s & ~cs_p;
    assign sample_en = sck_rise & ~cs_s;

    // Frame capture
    logic [FRAME_W-1:0] frame;
    logic [CW-1:0]      bit_cnt;

    spi_cmd_shifter #(
        .FRAME_W (FRAME_W)
    ) u_shift (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cs_fall),
        .en_i   (sample_en),
        .din_i  (mosi_s),
        .data_o (frame),
        .cnt_o  (bit_cnt)
    );

    // Frame judgement
    logic             len_ok, par_ok;
    logic [OP_W-1:0]  f_op;
    logic [RND_W-1:0] f_rnd;
    logic [KEY_W-1:0] f_keys;

    assign len_ok = (bit_cnt == CW'(FRAME_W));
    assign par_ok = ~(^frame);
    assign f_op   = frame[FRAME_W-1 -: OP_W];
    assign f_rnd  = frame[OP_LSB-1 -: RND_W];
    assign f_keys = frame[KEY_LSB +: KEY_W];

    // Controller
    rx_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            S_IDLE:  if (cs_fall) state_nxt = S_RECV;
            S_RECV:  if (cs_rise) state_nxt = S_EVAL;
            S_EVAL:  state_nxt = cs_fall ? S_RECV : S_IDLE;
            default: state_nxt = S_IDLE;
        endcase
    end

    // Commit and status
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_valid_o   <= 1'b0;
            cmd_op_o      <= '0;
            cmd_rand_o    <= '0;
            cmd_keys_o    <= '0;
            parity_err_o  <= 1'b0;
            framing_err_o <= 1'b0;
        end else begin
            cmd_valid_o <= 1'b0;
            if (state == S_EVAL) begin
                if (!len_ok) begin
                    framing_err_o <= 1'b1;
                end else if (!par_ok) begin
                    parity_err_o <= 1'b1;
                end else begin
                    cmd_valid_o <= 1'b1;
                    if (f_op == CLR_OP) begin
                        parity_err_o  <= 1'b0;
                        framing_err_o <= 1'b0;
                    end else begin
                        cmd_op_o   <= f_op;
                        cmd_rand_o <= f_rnd;
                        cmd_keys_o <= f_keys;
                    end
                end
            end
        end
    end

    // R3: the valid pulse never lasts beyond one clock
    p_valid_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |=> !cmd_valid_o);

    // R3: a valid pulse follows directly on an evaluation cycle
    p_valid_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> $past(state == S_EVAL));

    // R4: command fields move only together with a valid pulse
    p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cmd_op_o, cmd_rand_o, cmd_keys_o}) |-> cmd_valid_o);

    // R5: a framing error is raised only by an evaluation, without valid
    p_ferr_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(framing_err_o) |-> ($past(state == S_EVAL) && !cmd_valid_o));

    // R7: error flags drop only on an accepted frame
    p_flag_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(parity_err_o) || $fell(framing_err_o)) |-> cmd_valid_o);

endmodule

// File: tb/spi_cmd_rx_test.sv
module spi_cmd_rx_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       cs_n = 1'b1;
    logic       cmd_valid;
    logic [3:0] cmd_op;
    logic [2:0] cmd_rand;
    logic [7:0] cmd_keys;
    logic       perr, ferr;

    int checks = 0;
    int fails  = 0;
    int vcount = 0;
    bit done   = 0;
    logic v3, v4, v5;

    always #10 clk = ~clk;

    spi_cmd_rx uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .spi_sck_i     (sck),
        .spi_mosi_i    (mosi),
        .spi_cs_n_i    (cs_n),
        .cmd_valid_o   (cmd_valid),
        .cmd_op_o      (cmd_op),
        .cmd_rand_o    (cmd_rand),
        .cmd_keys_o    (cmd_keys),
        .parity_err_o  (perr),
        .framing_err_o (ferr)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Behavioural reference, advanced on every rising edge
    logic       m_prev_sck = 1'b0, m_prev_cs = 1'b1;
    logic       q[$];
    int         pend = 0;
    int         pend_len = 0;
    logic [15:0] pend_bits = '0;
    logic       e_valid = 0, e_perr = 0, e_ferr = 0;
    logic [3:0] e_op = 0;
    logic [2:0] e_rand = 0;
    logic [7:0] e_keys = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_prev_sck = 1'b0; m_prev_cs = 1'b1; q.delete(); pend = 0;
            e_valid = 0; e_perr = 0; e_ferr = 0; e_op = 0; e_rand = 0; e_keys = 0;
        end else begin
            e_valid = 0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    if (pend_len != 16)      e_ferr = 1;
                    else if (^pend_bits)     e_perr = 1;
                    else begin
                        e_valid = 1;
                        if (pend_bits[15:12] == 4'hF) begin
                            e_perr = 0; e_ferr = 0;
                        end else begin
                            e_op = pend_bits[15:12]; e_rand = pend_bits[11:9]; e_keys = pend_bits[8:1];
                        end
                    end
                end
            end
            if (m_prev_cs && !cs_n) q.delete();
            if (!cs_n && sck && !m_prev_sck) q.push_back(mosi);
            if (!m_prev_cs && cs_n) begin
                pend = 3;
                pend_len = q.size();
                pend_bits = '0;
                for (int i = 0; i < 16 && i < q.size(); i++) pend_bits[15-i] = q[i];
            end
            m_prev_sck = sck;
            m_prev_cs  = cs_n;
        end
    end

    // Per-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(cmd_valid == e_valid, "R3 valid", cmd_valid, e_valid);
            chk({cmd_op, cmd_rand, cmd_keys} == {e_op, e_rand, e_keys}, "R2 fields",
                {cmd_op, cmd_rand, cmd_keys}, {e_op, e_rand, e_keys});
            chk(perr == e_perr, "R4 parity flag", perr, e_perr);
            chk(ferr == e_ferr, "R5 framing flag", ferr, e_ferr);
            if (cmd_valid) vcount++;
        end
    end

    function automatic logic [15:0] mk(input logic [3:0] op, input logic [2:0] r, input logic [7:0] k);
        logic [14:0] b;
        b = {op, r, k};
        return {b, ^b};
    endfunction

    task automatic send(input logic [31:0] d, input int n, input int half, input int gap);
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = n - 1; i >= 0; i--) begin
            mosi = d[i];
            sck  = 1'b0;
            repeat (half) @(negedge clk);
            sck = 1'b1;
            repeat (half) @(negedge clk);
        end
        sck = 1'b0;
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        if (gap >= 5) begin
            repeat (3) @(negedge clk); v3 = cmd_valid;
            @(negedge clk);            v4 = cmd_valid;
            @(negedge clk);            v5 = cmd_valid;
            repeat (gap - 5) @(negedge clk);
        end else begin
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic finish_up;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_up();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1: reset state
        chk({cmd_valid, cmd_op, cmd_rand, cmd_keys, perr, ferr} == '0, "R1 reset",
            {cmd_valid, cmd_op, cmd_rand, cmd_keys, perr, ferr}, 0);

        // R8: serial clock toggling with chip-select high
        mosi = 1'b1;
        for (int i = 0; i < 20; i++) begin
            sck = ~sck;
            repeat (2) @(negedge clk);
        end
        sck = 1'b0;
        repeat (6) @(negedge clk);
        chk(vcount == 0 && {cmd_op, cmd_rand, cmd_keys} == '0, "R8 idle sck",
            {vcount[7:0], cmd_op, cmd_rand, cmd_keys}, 0);

        // R2 and R3: good frame
        send(32'(mk(4'h1, 3'd5, 8'hA5)), 16, 3, 8);
        chk({cmd_op, cmd_rand, cmd_keys} == {4'h1, 3'd5, 8'hA5}, "R2 fields",
            {cmd_op, cmd_rand, cmd_keys}, {4'h1, 3'd5, 8'hA5});
        chk({v3, v4, v5} == 3'b010, "R3 pulse timing", {v3, v4, v5}, 3'b010);
        chk(vcount == 1, "R3 single pulse", vcount, 1);

        // R4: parity failure
        send(32'(mk(4'h2, 3'd6, 8'h11) ^ 16'h1), 16, 3, 8);
        chk({cmd_op, cmd_rand, cmd_keys} == {4'h1, 3'd5, 8'hA5}, "R4 hold",
            {cmd_op, cmd_rand, cmd_keys}, {4'h1, 3'd5, 8'hA5});
        chk(perr == 1'b1 && vcount == 1, "R4 flag", {perr, vcount[7:0]}, {1'b1, 8'd1});

        // R6 and R8: fast serial clock, flag stays set
        send(32'(mk(4'h3, 3'd2, 8'h3C)), 16, 1, 8);
        chk({cmd_op, cmd_rand, cmd_keys} == {4'h3, 3'd2, 8'h3C}, "R8 fast sck",
            {cmd_op, cmd_rand, cmd_keys}, {4'h3, 3'd2, 8'h3C});
        chk(perr == 1'b1, "R6 sticky", perr, 1);

        // R5: short frame
        send(32'(mk(4'h4, 3'd1, 8'hFF) >> 4), 12, 3, 8);
        chk(ferr == 1'b1 && vcount == 2, "R5 short", {ferr, vcount[7:0]}, {1'b1, 8'd2});
        chk({cmd_op, cmd_rand, cmd_keys} == {4'h3, 3'd2, 8'h3C}, "R5 hold",
            {cmd_op, cmd_rand, cmd_keys}, {4'h3, 3'd2, 8'h3C});

        // R7: clear with bad parity does nothing
        send(32'(mk(4'hF, 3'd0, 8'h00) ^ 16'h1), 16, 3, 8);
        chk(perr && ferr && vcount == 2, "R7 bad clear", {perr, ferr, vcount[7:0]}, {2'b11, 8'd2});

        // R7: clear
        send(32'(mk(4'hF, 3'd7, 8'hFF)), 16, 3, 8);
        chk(!perr && !ferr && vcount == 3, "R7 clear", {perr, ferr, vcount[7:0]}, {2'b00, 8'd3});
        chk({cmd_op, cmd_rand, cmd_keys} == {4'h3, 3'd2, 8'h3C}, "R7 data kept",
            {cmd_op, cmd_rand, cmd_keys}, {4'h3, 3'd2, 8'h3C});

        // R5: long frame
        send({15'd0, mk(4'h5, 3'd3, 8'h42), 1'b0}, 17, 2, 8);
        chk(ferr == 1'b1 && vcount == 3, "R5 long", {ferr, vcount[7:0]}, {1'b1, 8'd3});
        send(32'(mk(4'hF, 3'd0, 8'h00)), 16, 2, 8);
        chk(!ferr && vcount == 4, "R7 clear again", {ferr, vcount[7:0]}, {1'b0, 8'd4});

        // R9: back-to-back frames
        send(32'(mk(4'h6, 3'd4, 8'h81)), 16, 2, 1);
        send(32'(mk(4'h7, 3'd1, 8'h7E)), 16, 2, 10);
        chk(vcount == 6, "R9 both accepted", vcount, 6);
        chk({cmd_op, cmd_rand, cmd_keys} == {4'h7, 3'd1, 8'h7E}, "R9 last frame",
            {cmd_op, cmd_rand, cmd_keys}, {4'h7, 3'd1, 8'h7E});

        finish_up();
    end

endmodule